// File: doc/BRIEF.md
# Multi-Locality Access Arbiter

This block decides which of five software localities owns a shared security-coprocessor register interface at any moment. Each locality sees its own one-byte access register. The locality number comes from address bits [14:12], and the register sits at offset zero within that locality's 4 KiB window. Through that register a locality can ask for the interface, see whether it currently owns it, learn whether someone else is waiting, and hand ownership back.

The bus side is a plain register port: a write strobe with address and byte data, and a read data output that follows the address combinationally. The block exports the current owner as a valid flag plus a locality number. It also gives a one-cycle change pulse that downstream interrupt logic can turn into a locality-change interrupt.

Requests are queued as one bit per locality. A request made while the interface is idle is granted on the following clock edge. When the owner releases, the edge after the release grants the highest-numbered waiting locality.

Top module: `locality_owner_arb`

## Requirements
- R1: After reset no locality is active, no request is queued and the change pulse is low; every locality's access register then reads 0x80.
- R2: Bit 7 of the access register (address bits [11:0] zero, address bits [14:12] in 0..4) always reads 1. A read at any other offset, or in locality 5..7, returns 0x00.
- R3: Writing a byte with bit 1 set to an idle interface's access register queues that locality. It becomes the owner on the next clock edge, and bit 5 then reads 1 in its register only.
- R4: Bit 2 reads 1 in the owner's access register while any other locality has a queued request. It reads 0 in every register that is not the owner's.
- R5: The owner gives up ownership by writing a byte with bit 5 set to its own access register. The interface is then idle after that edge, and ownership never moves straight from one locality to another without an idle cycle.
- R6: On the edge after a release, the highest-numbered locality with a queued request becomes the owner, and its request is removed from the queue.
- R7: A write with bit 5 set to the access register of a locality that is not the owner has no effect.
- R8: A request written by the current owner has no effect: bit 1 and bit 2 of its register do not change.
- R9: The change output is high for exactly the one cycle after each edge at which the owner valid flag or owner number changes, and low otherwise.
- R10: Writes to offsets other than zero, or to localities 5..7, change no state.
- R11: Bit 1 of a locality's access register reads 1 while that locality has a queued request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 15 | Byte address; bits [14:12] select the locality |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| owner_valid | output | 1 | Some locality owns the interface |
| owner_loc | output | 3 | Number of the owning locality, meaningful when owner_valid is high |
| owner_change | output | 1 | One-cycle pulse after the owner changed |

## Verification
The assertions assume that reset is held low for at least one clock edge before it is released, and that bus_wr, bus_addr and bus_wdata are stable around each rising edge. They also treat any write whose bit 5 is set and which targets the owner's register as a release, regardless of the other bits in that write. The bench drives every input on the falling edge, holds reset for several cycles, and samples outputs on the next falling edge. This keeps stimulus and checks half a period away from the edge where the state changes.

// File: rtl/loc_arb_pkg.sv
// Package: shared field positions of the per-locality access register.
// Assumes an 8-bit access register; positions are fixed by software usage.
package loc_arb_pkg;
    localparam int ACC_VALID_BIT  = 7;
    localparam int ACC_ACTIVE_BIT = 5;
    localparam int ACC_PEND_BIT   = 2;
    localparam int ACC_REQ_BIT    = 1;
    localparam int ACC_BYTE_W     = 8;
endpackage

// File: rtl/loc_addr_decode.sv
// Module: turns a bus address into a locality index, a register-hit flag
// and a one-hot write strobe per locality.
// Assumes the access register is at offset zero of each locality window.
module loc_addr_decode #(
    parameter int NUM_LOC   = 5,
    parameter int ADDR_W    = 15,
    parameter int LOC_SHIFT = 12,
    localparam int LOC_W    = ADDR_W - LOC_SHIFT
) (
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    output logic [LOC_W-1:0]   loc_idx,
    output logic               reg_hit,
    output logic [NUM_LOC-1:0] wr_vec
);
    // Purpose: split the address and check the offset and locality range.
    always_comb begin
        loc_idx = bus_addr[ADDR_W-1:LOC_SHIFT];
        reg_hit = (bus_addr[LOC_SHIFT-1:0] == '0) &&
                  ({1'b0, loc_idx} < (LOC_W+1)'(NUM_LOC));
    end

    // One write strobe per locality.
    for (genvar g = 0; g < NUM_LOC; g++) begin : g_wr
        assign wr_vec[g] = bus_wr && reg_hit && (loc_idx == LOC_W'(g));
    end
endmodule

// File: rtl/loc_prio_pick.sv
// Module: picks the highest-numbered set bit of the request vector.
// Assumes nothing about the request source; purely combinational.
module loc_prio_pick #(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3
) (
    input  logic [NUM_LOC-1:0] req_vec,
    output logic               pick_valid,
    output logic [LOC_W-1:0]   pick_idx
);
    // Purpose: scan upward so the last (highest) set bit wins.
    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        for (int i = 0; i < NUM_LOC; i++) begin
            if (req_vec[i]) begin
                pick_valid = 1'b1;
                pick_idx   = LOC_W'(i);
            end
        end
    end
endmodule

// File: rtl/loc_req_queue.sv
// Module: one queued-request flag per locality.
// Assumes set requests from the current owner are already masked by the caller,
// and that grant_vec is one-hot or zero.
module loc_req_queue #(
    parameter int NUM_LOC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LOC-1:0] set_vec,
    input  logic [NUM_LOC-1:0] grant_vec,
    output logic [NUM_LOC-1:0] req_vec
);
    // Purpose: add new requests, drop the one being granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_vec <= '0;
        end else begin
            req_vec <= (req_vec | set_vec) & ~grant_vec;
        end
    end
endmodule

// File: rtl/loc_owner_state.sv
// Module: holds the current owner and raises a one-cycle change pulse.
// Assumes release and grant are never requested in the same cycle
// (grant only happens when idle, release only when owned).
module loc_owner_state #(
    parameter int LOC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             release_fire,
    input  logic             grant_fire,
    input  logic [LOC_W-1:0] grant_idx,
    output logic             owner_valid,
    output logic [LOC_W-1:0] owner_loc,
    output logic             owner_change
);
    // Purpose: update ownership and register the change event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_valid  <= 1'b0;
            owner_loc    <= '0;
            owner_change <= 1'b0;
        end else begin
            owner_change <= release_fire || grant_fire;
            if (release_fire) begin
                owner_valid <= 1'b0;
            end else if (grant_fire) begin
                owner_valid <= 1'b1;
                owner_loc   <= grant_idx;
            end
        end
    end
endmodule

// File: rtl/locality_owner_arb.sv
// Module: top of the locality ownership arbiter. Decodes the access register
// of each locality, queues requests, grants idle ownership to the highest
// waiting locality and returns the access register on reads.
// Assumes a single-cycle write port and a combinational read path.
module locality_owner_arb #(
    parameter int NUM_LOC   = 5,
    parameter int ADDR_W    = 15,
    parameter int LOC_SHIFT = 12,
    localparam int LOC_W    = ADDR_W - LOC_SHIFT,
    localparam int DATA_W   = loc_arb_pkg::ACC_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              owner_valid,
    output logic [LOC_W-1:0]  owner_loc,
    output logic              owner_change
);
    import loc_arb_pkg::*;

    logic [LOC_W-1:0]   loc_idx;
    logic               reg_hit;
    logic [NUM_LOC-1:0] wr_vec;
    logic [NUM_LOC-1:0] req_vec;
    logic [NUM_LOC-1:0] owner_oh;
    logic [NUM_LOC-1:0] grant_vec;
    logic [NUM_LOC-1:0] set_vec;
    logic               pick_valid;
    logic [LOC_W-1:0]   pick_idx;
    logic               grant_fire;
    logic               release_fire;
    logic               unused_wbits;

    assign unused_wbits = ^bus_wdata;

    loc_addr_decode #(
        .NUM_LOC(NUM_LOC), .ADDR_W(ADDR_W), .LOC_SHIFT(LOC_SHIFT)
    ) u_dec (
        .bus_wr(bus_wr), .bus_addr(bus_addr),
        .loc_idx(loc_idx), .reg_hit(reg_hit), .wr_vec(wr_vec)
    );

    loc_prio_pick #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_pick (
        .req_vec(req_vec), .pick_valid(pick_valid), .pick_idx(pick_idx)
    );

    // Per-locality owner flag, grant strobe and masked request set.
    for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
        assign owner_oh[g]  = owner_valid && (owner_loc == LOC_W'(g));
        assign grant_vec[g] = grant_fire && (pick_idx == LOC_W'(g));
        assign set_vec[g]   = wr_vec[g] && bus_wdata[ACC_REQ_BIT] &&
                              !owner_oh[g] && !grant_vec[g];
    end

    // Purpose: decide grant (idle only) and release (owner only).
    always_comb begin
        grant_fire   = !owner_valid && pick_valid;
        release_fire = |(wr_vec & owner_oh) && bus_wdata[ACC_ACTIVE_BIT];
    end

    loc_req_queue #(.NUM_LOC(NUM_LOC)) u_queue (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
        .grant_vec(grant_vec), .req_vec(req_vec)
    );

    loc_owner_state #(.LOC_W(LOC_W)) u_owner (
        .clk(clk), .rst_n(rst_n), .release_fire(release_fire),
        .grant_fire(grant_fire), .grant_idx(pick_idx),
        .owner_valid(owner_valid), .owner_loc(owner_loc),
        .owner_change(owner_change)
    );

    // Purpose: assemble the addressed locality's access register.
    always_comb begin
        bus_rdata = '0;
        if (reg_hit) begin
            bus_rdata[ACC_VALID_BIT] = 1'b1;
            for (int i = 0; i < NUM_LOC; i++) begin
                if (loc_idx == LOC_W'(i)) begin
                    bus_rdata[ACC_ACTIVE_BIT] = owner_oh[i];
                    bus_rdata[ACC_PEND_BIT]   = owner_oh[i] && (|req_vec);
                    bus_rdata[ACC_REQ_BIT]    = req_vec[i];
                end
            end
        end
    end
endmodule

// File: rtl/loc_arb_chk.sv
// Checker: temporal properties of the ownership arbiter at its ports.
// Assumes reset is held low for at least one edge before release.
module loc_arb_chk #(
    parameter int NUM_LOC   = 5,
    parameter int ADDR_W    = 15,
    parameter int LOC_SHIFT = 12,
    localparam int LOC_W    = ADDR_W - LOC_SHIFT
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              owner_valid,
    input logic [LOC_W-1:0]  owner_loc,
    input logic              owner_change
);
    logic rd_hit;
    assign rd_hit = (bus_addr[LOC_SHIFT-1:0] == '0) &&
                    ({1'b0, bus_addr[ADDR_W-1:LOC_SHIFT]} < (LOC_W+1)'(NUM_LOC));

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!owner_valid && !owner_change));

    // R2
    valid_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> bus_rdata[7]);

    // R2
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> (bus_rdata == 8'h00));

    // R5
    no_direct_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_valid && $past(owner_valid)) |-> (owner_loc == $past(owner_loc)));

    // R7
    release_by_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(owner_valid) |-> ($past(bus_wr) && $past(bus_wdata[5]) &&
            ($past(bus_addr[LOC_SHIFT-1:0]) == '0) &&
            ($past(bus_addr[ADDR_W-1:LOC_SHIFT]) == $past(owner_loc))));

    // R9
    change_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owner_change |-> !$stable({owner_valid, owner_loc}));

    // R9
    change_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable({owner_valid, owner_loc}) && !$rose(rst_n)) |-> owner_change);
endmodule

bind locality_owner_arb loc_arb_chk #(
    .NUM_LOC(NUM_LOC), .ADDR_W(ADDR_W), .LOC_SHIFT(LOC_SHIFT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .owner_valid(owner_valid),
    .owner_loc(owner_loc), .owner_change(owner_change)
);

// File: tb/tb_locality_owner_arb.sv
module tb_locality_owner_arb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [14:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        owner_valid;
    logic [2:0]  owner_loc;
    logic        owner_change;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    locality_owner_arb dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .owner_valid(owner_valid),
        .owner_loc(owner_loc), .owner_change(owner_change)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Write one byte; returns at the falling edge after the write edge.
    task automatic wr(input int loc, input int off, input int data);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = {3'(loc), 12'(off)};
        bus_wdata = 8'(data);
        @(negedge clk);
        bus_wr = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd(input int loc, input int off, output int val);
        bus_addr = {3'(loc), 12'(off)};
        #0.5;
        val = int'(bus_rdata);
    endtask

    task automatic owner_is(input string req, input int v, input int l, input int chg);
        check({req, " valid"}, int'(owner_valid), v);
        if (v != 0) check({req, " loc"}, int'(owner_loc), l);
        check({req, " change"}, int'(owner_change), chg);
    endtask

    task automatic t_reset();
        int v;
        owner_is("R1", 0, 0, 0);
        for (int l = 0; l < 5; l++) begin
            rd(l, 0, v);
            check("R1", v, 8'h80);
        end
    endtask

    task automatic t_decode();
        int v;
        rd(5, 0, v); check("R2 loc5", v, 0);
        rd(7, 0, v); check("R2 loc7", v, 0);
        rd(0, 12'h018, v); check("R2 offset", v, 0);
        rd(2, 0, v); check("R2 valid", v, 8'h80);
        wr(6, 0, 8'h02);
        wr(0, 12'h018, 8'h02);
        @(negedge clk);
        owner_is("R10", 0, 0, 0);
        rd(0, 0, v); check("R10 no req", v, 8'h80);
    endtask

    task automatic t_grant_idle();
        int v;
        wr(1, 0, 8'h02);
        owner_is("R3 not yet", 0, 0, 0);
        rd(1, 0, v); check("R11 queued", v, 8'h82);
        @(negedge clk);
        owner_is("R3 R9 grant", 1, 1, 1);
        rd(1, 0, v); check("R3 owner reg", v, 8'hA0);
        rd(0, 0, v); check("R3 other reg", v, 8'h80);
        @(negedge clk);
        owner_is("R9 one cycle", 1, 1, 0);
    endtask

    task automatic t_pending();
        int v;
        wr(0, 0, 8'h02);
        wr(3, 0, 8'h02);
        @(negedge clk);
        owner_is("R4 kept", 1, 1, 0);
        rd(1, 0, v); check("R4 owner pending", v, 8'hA4);
        rd(3, 0, v); check("R4 R11 waiter", v, 8'h82);
        rd(0, 0, v); check("R4 R11 waiter0", v, 8'h82);
    endtask

    task automatic t_nonowner_release();
        int v;
        wr(3, 0, 8'h20);
        owner_is("R7 ignored", 1, 1, 0);
        @(negedge clk);
        owner_is("R7 still", 1, 1, 0);
        rd(3, 0, v); check("R7 req kept", v, 8'h82);
    endtask

    task automatic t_rerequest();
        int v;
        wr(1, 0, 8'h02);
        @(negedge clk);
        owner_is("R8", 1, 1, 0);
        rd(1, 0, v); check("R8 reg", v, 8'hA4);
    endtask

    task automatic t_release_prio();
        int v;
        wr(1, 0, 8'h20);
        owner_is("R5 R9 idle", 0, 0, 1);
        @(negedge clk);
        owner_is("R6 highest", 1, 3, 1);
        rd(3, 0, v); check("R6 R4 new owner", v, 8'hA4);
        rd(1, 0, v); check("R5 old owner", v, 8'h80);
        wr(3, 0, 8'h20);
        owner_is("R5 idle2", 0, 0, 1);
        @(negedge clk);
        owner_is("R6 last waiter", 1, 0, 1);
        rd(0, 0, v); check("R4 no pending", v, 8'hA0);
        wr(0, 0, 8'h20);
        owner_is("R5 idle3", 0, 0, 1);
        @(negedge clk);
        owner_is("R9 quiet", 0, 0, 0);
        @(negedge clk);
        owner_is("R9 quiet2", 0, 0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_grant_idle();
        t_pending();
        t_nonowner_release();
        t_rerequest();
        t_release_prio();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule